// File: doc/BRIEF.md
# Multi-Sector Flash Erase Sequencer

This engine sits on the host side of a parallel NOR flash that is wired to an asynchronous, SRAM-style bus. Software or a neighbouring block loads sector addresses into a small queue and pulses `start`. The engine first writes the six-cycle erase command sequence for the sector at the head of the queue. It then keeps taking further queued sectors, one command write each, for as long as the next write can still finish before the flash's inter-command deadline. After that it reads the last commanded sector over and over until the byte reads all ones. A sector that shows up too late for the open window waits in the queue and starts a fresh full sequence once the current batch is complete. No preprogramming writes are ever issued, because the flash does that step itself.

If polling never returns all ones, the engine gives up after a set number of reads and reports an error. A pulse on `abort` drives the flash reset pin low. The engine then waits for the part to recover and issues the whole command sequence again for every sector of the interrupted batch.

The engine's states are IDLE, UNLOCK, ERASE, WINDOW, POLL, RSTLO and RSTWAIT.
- IDLE→UNLOCK: on a start with sectors queued.
- UNLOCK steps through five writes, then UNLOCK→ERASE.
- ERASE→WINDOW: after the sector command write.
- WINDOW→ERASE: a further sector is queued while the window is open.
- WINDOW→POLL: the window has closed.
- POLL→IDLE: all ones with the queue empty, or the poll limit is reached.
- POLL→UNLOCK: all ones with deferred sectors still queued.
- Any active state→RSTLO: on abort.
- RSTLO→RSTWAIT→UNLOCK: once the reset pulse and the recovery time are over.

Top module: `flash_erase_seq`

## Requirements
- R1: One erase sequence is exactly these writes, as (address, data) in this order: (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (sector,0x30). No other write, such as a program command, is issued.
- R2: Every write cycle holds `fl_ce_n` and `fl_we_n` low for exactly WR_CYC clocks while `fl_oe_n` stays high. Address and data stay unchanged through the clock in which `fl_we_n` returns high.
- R3: After the command writes, the engine reads the last commanded sector repeatedly. It pulses `done` with `err` low once a read returns all ones.
- R4: A sector that is queued while the window is open is issued as a single (sector,0x30) write. The gap between consecutive `fl_we_n` rising edges in a batch is always under DEADLINE_CYC clocks.
- R5: A sector that arrives after the window has closed is erased by a new complete six-write sequence after the current batch finishes, and `done` pulses only once, at the very end.
- R6: If POLL_MAX reads in a row do not return all ones, `done` and `err` pulse together and no further read follows.
- R7: `abort` during an active erase holds `fl_rst_n` low for RST_CYC clocks with `fl_ce_n` high. After RECOV_CYC more clocks the full sequence is reissued for the same batch.
- R8: `start` with an empty queue gives `done` on the next clock and causes no bus cycle.
- R9: The queue holds DEPTH sectors. `sec_full` reports when it is full, and a push while it is full is dropped.
- R10: After reset, `done`, `err` and `fl_dq_oe` are low and `fl_ce_n`, `fl_oe_n`, `fl_we_n` and `fl_rst_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin erasing the queued sectors |
| abort | input | 1 | Hardware-reset the flash and restart the batch |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Poll timeout, pulses together with done |
| sec_push | input | 1 | Push `sec_addr` into the queue |
| sec_addr | input | AW | Sector address to queue |
| sec_full | output | 1 | Queue full |
| fl_addr | output | AW | Flash address |
| fl_dout | output | DW | Flash write data |
| fl_din | input | DW | Flash read data |
| fl_dq_oe | output | 1 | Drive enable for the data bus |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_rst_n | output | 1 | Flash hardware reset, active low |

## Verification
The bench builds the engine with WR_CYC=2, RD_CYC=2, DEADLINE_CYC=20, POLL_MAX=8, DEPTH=4, RST_CYC=3 and RECOV_CYC=4. The short deadline lets a sector pushed during the first poll read land clearly after the window has closed. The small poll limit makes a timeout reachable within a few dozen clocks. A four-entry queue can be overfilled with a fifth push. The short reset and recovery times let one test cover an abort mid-poll, the replay and the final completion.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_UNLOCK, S_ERASE, S_WINDOW, S_POLL, S_RSTLO, S_RSTWAIT
    } seq_state_t;

    typedef enum logic [1:0] {B_IDLE, B_ACT, B_GAP} bus_phase_t;

    localparam logic [7:0] CMD_SECTOR = 8'h30;

    function automatic logic [11:0] step_addr(input logic [2:0] s);
        case (s)
            3'd1, 3'd4: return 12'h2AA;
            default:    return 12'h555;
        endcase
    endfunction

    function automatic logic [7:0] step_data(input logic [2:0] s);
        case (s)
            3'd1, 3'd4: return 8'h55;
            3'd2:       return 8'h80;
            default:    return 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/sector_queue.sv
module sector_queue #(
    parameter int AW    = 20,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    input  logic          commit,
    input  logic          rewind,
    output logic          full,
    output logic          avail,
    output logic [AW-1:0] head
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] FULLV = PW'(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr, bptr;

    assign full  = (wptr - bptr) == FULLV;
    assign avail = rptr != wptr;
    assign head  = mem[rptr[PW-2:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            bptr <= '0;
        end else begin
            if (push && !full) begin
                mem[wptr[PW-2:0]] <= push_addr;
                wptr <= wptr + 1'b1;
            end
            if (rewind)
                rptr <= bptr;
            else if (pop && avail)
                rptr <= rptr + 1'b1;
            if (commit)
                bptr <= rptr;
        end
    end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_erase_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 8,
    parameter int WR_CYC = 2,
    parameter int RD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kill,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ack,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int LMAX = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int CW   = $clog2(LMAX + 1);

    bus_phase_t    phase;
    logic [CW-1:0] cnt;
    logic          lat_wr;
    logic [CW-1:0] last;

    assign last = lat_wr ? CW'(WR_CYC - 1) : CW'(RD_CYC - 1);

    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            phase   <= B_IDLE;
            cnt     <= '0;
            lat_wr  <= 1'b0;
            fl_addr <= '0;
            fl_dout <= '0;
            rdata   <= '0;
        end else begin
            unique case (phase)
                B_IDLE: if (req) begin
                    phase   <= B_ACT;
                    cnt     <= '0;
                    lat_wr  <= wr;
                    fl_addr <= addr;
                    fl_dout <= wdata;
                end
                B_ACT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == last) begin
                        phase <= B_GAP;
                        if (!lat_wr) rdata <= fl_din;
                    end
                end
                B_GAP: phase <= B_IDLE;
                default: phase <= B_IDLE;
            endcase
        end
    end

    assign ack      = phase == B_GAP;
    assign fl_ce_n  = phase != B_ACT;
    assign fl_we_n  = !(phase == B_ACT && lat_wr);
    assign fl_oe_n  = !(phase == B_ACT && !lat_wr);
    assign fl_dq_oe = lat_wr && phase != B_IDLE;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DW           = 8,
    parameter int DEPTH        = 4,
    parameter int WR_CYC       = 2,
    parameter int RD_CYC       = 2,
    parameter int DEADLINE_CYC = 2500,
    parameter int POLL_MAX     = 100000,
    parameter int RST_CYC      = 25,
    parameter int RECOV_CYC    = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    output logic          done,
    output logic          err,
    input  logic          sec_push,
    input  logic [AW-1:0] sec_addr,
    output logic          sec_full,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n,
    output logic          fl_rst_n
);
    localparam int WIN_LIM = DEADLINE_CYC - WR_CYC - 3;
    localparam int T1      = (RST_CYC > RECOV_CYC) ? RST_CYC : RECOV_CYC;
    localparam int TMAX    = (T1 > DEADLINE_CYC) ? T1 : DEADLINE_CYC;
    localparam int TW      = $clog2(TMAX + 1);
    localparam int PCW     = $clog2(POLL_MAX + 1);

    seq_state_t     st, st_n;
    logic [2:0]     step, step_n;
    logic [TW-1:0]  tmr, tmr_n;
    logic [PCW-1:0] pcnt, pcnt_n;
    logic [AW-1:0]  paddr, paddr_n;
    logic           pop, commit, rewind, kill, done_set, err_set, abort_take;
    logic           avail, ack, req, wr;
    logic [AW-1:0]  head, req_addr;
    logic [DW-1:0]  req_data, rdata;

    sector_queue #(.AW(AW), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(sec_push), .push_addr(sec_addr),
        .pop(pop), .commit(commit), .rewind(rewind),
        .full(sec_full), .avail(avail), .head(head)
    );

    flash_bus_cycle #(.AW(AW), .DW(DW), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) u_bus (
        .clk(clk), .rst_n(rst_n), .kill(kill), .req(req), .wr(wr),
        .addr(req_addr), .wdata(req_data), .rdata(rdata), .ack(ack),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    assign abort_take = abort && (st == S_UNLOCK || st == S_ERASE ||
                                  st == S_WINDOW || st == S_POLL);
    assign req = (st == S_UNLOCK || st == S_ERASE || st == S_POLL) && !abort_take;
    assign wr  = st != S_POLL;

    always_comb begin
        req_addr = paddr;
        req_data = '0;
        if (st == S_UNLOCK) begin
            req_addr = AW'(step_addr(step));
            req_data = DW'(step_data(step));
        end else if (st == S_ERASE) begin
            req_addr = head;
            req_data = DW'(CMD_SECTOR);
        end
    end

    // next-state logic
    always_comb begin
        st_n = st; step_n = step; tmr_n = tmr; pcnt_n = pcnt; paddr_n = paddr;
        pop = 1'b0; commit = 1'b0; rewind = 1'b0; kill = 1'b0;
        done_set = 1'b0; err_set = 1'b0;
        if (abort_take) begin
            st_n = S_RSTLO; tmr_n = '0; kill = 1'b1;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    if (avail) begin st_n = S_UNLOCK; step_n = '0; end
                    else done_set = 1'b1;
                end
                S_UNLOCK: if (ack) begin
                    if (step == 3'd4) st_n = S_ERASE;
                    else step_n = step + 3'd1;
                end
                S_ERASE: if (ack) begin
                    pop = 1'b1; paddr_n = head; pcnt_n = '0; tmr_n = '0;
                    st_n = S_WINDOW;
                end
                S_WINDOW: begin
                    if (tmr >= TW'(WIN_LIM)) st_n = S_POLL;
                    else if (avail) st_n = S_ERASE;
                    else tmr_n = tmr + 1'b1;
                end
                S_POLL: if (ack) begin
                    if (rdata == '1) begin
                        commit = 1'b1;
                        if (avail) begin st_n = S_UNLOCK; step_n = '0; end
                        else begin st_n = S_IDLE; done_set = 1'b1; end
                    end else if (pcnt == PCW'(POLL_MAX - 1)) begin
                        commit = 1'b1; st_n = S_IDLE;
                        done_set = 1'b1; err_set = 1'b1;
                    end else pcnt_n = pcnt + 1'b1;
                end
                S_RSTLO: begin
                    kill = 1'b1;
                    if (tmr == TW'(RST_CYC - 1)) begin st_n = S_RSTWAIT; tmr_n = '0; end
                    else tmr_n = tmr + 1'b1;
                end
                S_RSTWAIT: begin
                    kill = 1'b1;
                    if (tmr == TW'(RECOV_CYC - 1)) begin
                        rewind = 1'b1; st_n = S_UNLOCK; step_n = '0;
                    end else tmr_n = tmr + 1'b1;
                end
                default: st_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; step <= '0; tmr <= '0; pcnt <= '0; paddr <= '0;
        end else begin
            st <= st_n; step <= step_n; tmr <= tmr_n; pcnt <= pcnt_n; paddr <= paddr_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; err <= 1'b0; fl_rst_n <= 1'b1;
        end else begin
            done     <= done_set;
            err      <= err_set;
            fl_rst_n <= st_n != S_RSTLO;
        end
    end
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk
    import flash_erase_pkg::*;
#(
    parameter int AW           = 20,
    parameter int DW           = 8,
    parameter int DEADLINE_CYC = 2500
) (
    input logic          clk,
    input logic          rst_n,
    input seq_state_t    st,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n,
    input logic          fl_rst_n
);
    localparam int GW = $clog2(2 * DEADLINE_CYC + 2);

    logic          we_q, gap_ok;
    logic [GW-1:0] gcnt;
    logic          rise;

    assign rise = fl_we_n && !we_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q <= 1'b1; gap_ok <= 1'b0; gcnt <= '0;
        end else begin
            we_q <= fl_we_n;
            if (st == S_IDLE || st == S_RSTLO || st == S_RSTWAIT || !fl_oe_n) begin
                gap_ok <= 1'b0; gcnt <= '0;
            end else if (rise) begin
                gap_ok <= 1'b1; gcnt <= GW'(1);
            end else if (gcnt != '1) gcnt <= gcnt + 1'b1;
        end
    end

    p_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && gap_ok) |-> (gcnt < GW'(DEADLINE_CYC)));

    p_we_needs_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && we_q == 1'b0) |-> ($stable(fl_addr) && $stable(fl_dout)));

    p_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_rst_n |-> fl_ce_n);

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
endmodule

bind flash_erase_seq flash_erase_chk #(.AW(AW), .DW(DW), .DEADLINE_CYC(DEADLINE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb_top;
    localparam int AW = 20, DW = 8, DEPTH = 4, WR_CYC = 2, RD_CYC = 2;
    localparam int DEADLINE_CYC = 20, POLL_MAX = 8, RST_CYC = 3, RECOV_CYC = 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0, sec_push = 1'b0;
    logic [AW-1:0] sec_addr = '0;
    logic done, err, sec_full, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout, fl_din;

    always #10 clk = ~clk;

    flash_erase_seq #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC),
        .DEADLINE_CYC(DEADLINE_CYC), .POLL_MAX(POLL_MAX), .RST_CYC(RST_CYC),
        .RECOV_CYC(RECOV_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .done(done), .err(err),
        .sec_push(sec_push), .sec_addr(sec_addr), .sec_full(sec_full),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din), .fl_dq_oe(fl_dq_oe),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_rst_n(fl_rst_n));

    int total = 0, bad = 0;

    // flash model and bus monitor, sampled on the falling edge
    logic [AW-1:0] wa [64];
    logic [DW-1:0] wd [64];
    int            wcyc [64];
    logic [AW-1:0] ra [64];
    int wn = 0, rn = 0, busy = 0, rdcnt = 0, dones = 0, errs = 0;
    int cyc = 0, we_lo = 0, rst_lo = 0, timing_bad = 0, quiet_bad = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] fall_addr = '0;
    logic [DW-1:0] fall_data = '0;
    logic [DW-1:0] din_r = '0;
    assign fl_din = din_r;

    always @(negedge clk) begin
        cyc++;
        if (done) dones++;
        if (err) errs++;
        if (!fl_rst_n) begin
            rst_lo++;
            if (!fl_ce_n) quiet_bad++;
        end
        if (!fl_we_n) begin
            if (prev_we) begin fall_addr = fl_addr; fall_data = fl_dout; end
            we_lo++;
            if (fl_ce_n || !fl_oe_n) timing_bad++;
        end else if (!prev_we) begin
            if (we_lo != WR_CYC || fl_addr != fall_addr || fl_dout != fall_data) timing_bad++;
            if (wn < 64) begin wa[wn] = fl_addr; wd[wn] = fl_dout; wcyc[wn] = cyc; end
            wn++;
            we_lo = 0;
            if (fl_dout == 8'h30) rdcnt = 0;
        end
        if (!fl_oe_n && prev_oe) begin
            if (rn < 64) ra[rn] = fl_addr;
            rn++;
            rdcnt++;
            din_r = (rdcnt > busy) ? 8'hFF : 8'h00;
        end
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(posedge clk); #1;
        wn = 0; rn = 0; dones = 0; errs = 0; rst_lo = 0; timing_bad = 0; quiet_bad = 0;
    endtask

    task automatic push(input logic [AW-1:0] a);
        @(negedge clk); sec_push = 1'b1; sec_addr = a;
        @(negedge clk); sec_push = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && dones == 0; i++) @(negedge clk);
    endtask

    // checks the six writes starting at log index base for sector s
    task automatic chk_seq(input int base, input logic [AW-1:0] s, input string tag);
        logic [AW-1:0] ea [6];
        logic [DW-1:0] ed [6];
        ea = '{20'h555, 20'h2AA, 20'h555, 20'h555, 20'h2AA, s};
        ed = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
        for (int k = 0; k < 6; k++) begin
            chk(wa[base+k] == ea[k], {tag, " write address"}, int'(wa[base+k]), int'(ea[k]));
            chk(wd[base+k] == ed[k], {tag, " write data"}, int'(wd[base+k]), int'(ed[k]));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!done && !err && !fl_dq_oe, "R10 idle outputs low", {done, err, fl_dq_oe}, 0);
        chk(fl_ce_n && fl_oe_n && fl_we_n && fl_rst_n, "R10 strobes high",
            {fl_ce_n, fl_oe_n, fl_we_n, fl_rst_n}, 4'hF);
    endtask

    task automatic t_single();
        clear_logs(); busy = 2;
        push(20'h1_0000); pulse_start(); wait_done(500);
        chk(wn == 6, "R1 write count", wn, 6);
        chk_seq(0, 20'h1_0000, "R1");
        chk(timing_bad == 0, "R2 write strobe width and hold", timing_bad, 0);
        chk(rn == 3, "R3 poll reads until all ones", rn, 3);
        chk(ra[0] == 20'h1_0000 && ra[2] == 20'h1_0000, "R3 poll address", int'(ra[2]), 20'h1_0000);
        chk(dones == 1 && errs == 0, "R3 done without err", errs, 0);
    endtask

    task automatic t_multi();
        clear_logs(); busy = 1;
        push(20'h2_0000); push(20'h3_0000); pulse_start(); wait_done(500);
        chk(wn == 7, "R4 appended write count", wn, 7);
        chk(wa[6] == 20'h3_0000 && wd[6] == 8'h30, "R4 appended sector command", int'(wa[6]), 20'h3_0000);
        chk(wcyc[6] - wcyc[5] < DEADLINE_CYC, "R4 gap under deadline", wcyc[6] - wcyc[5], DEADLINE_CYC);
        chk(ra[0] == 20'h3_0000, "R3 polls last sector", int'(ra[0]), 20'h3_0000);
    endtask

    task automatic t_defer();
        clear_logs(); busy = 2;
        push(20'h4_0000); pulse_start();
        for (int i = 0; i < 500 && rn == 0; i++) @(negedge clk);
        push(20'h5_0000);
        wait_done(800);
        chk(wn == 12, "R5 deferred sector gets fresh sequence", wn, 12);
        chk_seq(6, 20'h5_0000, "R5");
        chk(ra[3] == 20'h5_0000, "R5 second batch polled", int'(ra[3]), 20'h5_0000);
        repeat (3) @(negedge clk);
        chk(dones == 1, "R5 single done", dones, 1);
    endtask

    task automatic t_timeout();
        clear_logs(); busy = 100;
        push(20'h6_0000); pulse_start(); wait_done(800);
        chk(errs == 1, "R6 err on poll timeout", errs, 1);
        repeat (10) @(negedge clk);
        chk(rn == POLL_MAX, "R6 read count at timeout", rn, POLL_MAX);
    endtask

    task automatic t_abort();
        int base;
        clear_logs(); busy = 1000;
        push(20'h7_0000); pulse_start();
        for (int i = 0; i < 500 && rn < 2; i++) @(negedge clk);
        base = wn;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        busy = 1;
        wait_done(800);
        chk(rst_lo == RST_CYC, "R7 reset pulse length", rst_lo, RST_CYC);
        chk(quiet_bad == 0, "R7 bus quiet during reset", quiet_bad, 0);
        chk(wn == base + 6, "R7 full sequence reissued", wn, base + 6);
        chk_seq(base, 20'h7_0000, "R7");
        chk(dones == 1 && errs == 0, "R7 completes after replay", dones, 1);
    endtask

    task automatic t_empty();
        clear_logs();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b1, "R8 immediate done", done, 1);
        repeat (5) @(negedge clk);
        chk(wn == 0 && rn == 0, "R8 no bus cycles", wn + rn, 0);
    endtask

    task automatic t_full();
        clear_logs(); busy = 0;
        for (int i = 0; i < 4; i++) push(AW'(20'h8_0000 + i * 20'h1_0000));
        chk(sec_full == 1'b1, "R9 full flag", sec_full, 1);
        push(20'hF_0000);
        pulse_start(); wait_done(800);
        chk(wn == 9, "R9 extra push dropped", wn, 9);
        chk(wa[8] == 20'hB_0000, "R9 last queued sector", int'(wa[8]), 20'hB_0000);
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_multi();
        t_defer();
        t_timeout();
        t_abort();
        t_empty();
        t_full();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule